// File: doc/BRIEF.md
# Vectored Interrupt Controller with Shared Collision Vector

This block gathers a set of level-sensitive interrupt lines and passes them through a mask that software can write. It drives one interrupt request wire and a vector bus into a processor core. When exactly one unmasked line is pending, the core receives a vector that names that line. When two or more unmasked lines are pending at the same moment, the core receives one fixed shared vector instead. The block does not rank the lines by priority, so the interrupt service code must read the masked status and pick which line to serve.

Two non-maskable lines are collected on a separate path. Any of them being active raises a dedicated non-maskable request. A fatal-error input latches a status bit and drives a sticky fatal output that only reset clears. Software reaches the state through a small window of 32-bit registers. The accesses are single-cycle control accesses with no back-pressure: a strobe starts an access, read data and the error flag are registered and are valid in the cycle after the strobe, and no ready signal exists because the block accepts every access. Only word-sized accesses are acted on.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Port bit k of `irq_lines` maps to raw status bit k, at offset 0x4. In the clock edge after that line changes level, the raw bit takes the new level.
- R2: The masked status, at offset 0x8, is recomputed as the raw status AND the mask (offset 0x0) on any edge where a line changes or where the mask or raw status is written. It is updated on the same edge as those registers.
- R3: When exactly masked bit i is set, `irq_vec` is 0x31+i and `irq_req` is high. The outputs are registered and update on the edge after the cause.
- R4: When two or more masked bits are set, `irq_vec` is the shared value 0x30 and `irq_req` is high.
- R5: When the masked status is zero, `irq_req` is low and `irq_vec` is 0.
- R6: Bit j of `nmi_lines` sets or clears bit j of the non-maskable status, at offset 0xC, on a level change. `nmi_req` is high while any bit of that status is set.
- R7: `bus_size` encodes 0 as byte, 1 as halfword and 2 as word. Non-word reads return 0, and non-word writes change no register.
- R8: A word write to offset 0x0, 0x4, 0x8, 0xC or 0x10 loads that register directly, and the vector outputs follow on the same edge. A word read returns the register zero-extended in the cycle after the strobe.
- R9: An access to any other offset returns 0, raises `bus_err` for one cycle and changes no register.
- R10: A high `fatal_in` sets bit 0 of the fatal status, at offset 0x10, and sets `fatal_o`. `fatal_o` stays high until reset.
- R11: A synchronous active-high `rst` clears every register and drives all request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_IRQ | Maskable level interrupt lines |
| nmi_lines | input | NUM_NMI | Non-maskable level lines |
| fatal_in | input | 1 | Fatal-error event |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the strobe |
| bus_err | output | 1 | Undefined-offset flag, one cycle after the strobe |
| irq_req | output | 1 | Maskable interrupt request |
| irq_vec | output | VEC_W | Interrupt vector |
| nmi_req | output | 1 | Non-maskable request |
| fatal_o | output | 1 | Sticky fatal indication |

## Verification
The bench builds the block with its default parameters: 30 maskable lines, 2 non-maskable lines, a 5-bit offset and an 8-bit vector with a shared value of 0x30. This width lets the table reach the topmost line, whose vector is 0x4E, as well as the all-lines-pending case. The 5-bit offset reaches the unmapped offsets above 0x10, so the error path can be exercised. Directed steps check narrow accesses, direct loads of the status registers, and the non-maskable and fatal paths.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int NUM_REGS = 5;
  typedef enum logic [2:0] {
    RG_MASK   = 3'd0,
    RG_RAW    = 3'd1,
    RG_MASKED = 3'd2,
    RG_NMI    = 3'd3,
    RG_FATAL  = 3'd4
  } reg_id_e;

  // byte offset of register r in the window
  function automatic int reg_offset(input int r);
    return r * 4;
  endfunction
endpackage

// File: rtl/ivc_line_track.sv
module ivc_line_track #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[b] <= 1'b0;
      else     prev_q[b] <= lvl[b];
    end
    assign chg[b] = lvl[b] ^ prev_q[b];
  end
endmodule

// File: rtl/ivc_vec_encode.sv
module ivc_vec_encode #(
  parameter int W          = 30,
  parameter int VEC_W      = 8,
  parameter int SHARED_VEC = 'h30
) (
  input  logic [W-1:0]     pend,
  output logic [VEC_W-1:0] vec
);
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

  logic [IDX_W-1:0] low_idx;
  logic             seen;
  logic             multi;

  always_comb begin
    low_idx = '0;
    seen    = 1'b0;
    multi   = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (pend[i]) begin
        if (seen) multi = 1'b1;
        else      low_idx = IDX_W'(i);
        seen = 1'b1;
      end
    end
    if (!seen)      vec = '0;
    else if (multi) vec = VEC_W'(SHARED_VEC);
    else            vec = VEC_W'(SHARED_VEC + 1 + int'(low_idx));
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_IRQ    = 30,
  parameter int NUM_NMI    = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int VEC_W      = 8,
  parameter int SHARED_VEC = 'h30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic [NUM_NMI-1:0] nmi_lines,
  input  logic               fatal_in,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [1:0]         bus_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               nmi_req,
  output logic               fatal_o
);
  localparam int MAX_VEC = SHARED_VEC + NUM_IRQ;

  logic [NUM_IRQ-1:0] mask_q, raw_q, masked_q;
  logic [NUM_NMI-1:0] nmi_q;
  logic               fatal_q;

  logic [NUM_IRQ-1:0] irq_chg;
  logic [NUM_NMI-1:0] nmi_chg;

  ivc_line_track #(.W(NUM_IRQ)) u_irq_track (
    .clk(clk), .rst(rst), .lvl(irq_lines), .chg(irq_chg)
  );
  ivc_line_track #(.W(NUM_NMI)) u_nmi_track (
    .clk(clk), .rst(rst), .lvl(nmi_lines), .chg(nmi_chg)
  );

  // address decode
  logic [NUM_REGS-1:0] hit;
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    assign hit[r] = (int'(bus_addr) == reg_offset(r));
  end

  logic word_acc, bad_acc, wr_any;
  logic [NUM_REGS-1:0] wr;
  assign word_acc = bus_sel && (bus_size == SZ_WORD);
  assign bad_acc  = bus_sel && (hit == '0);
  assign wr_any   = word_acc && bus_we && !bad_acc;
  assign wr       = wr_any ? hit : '0;

  // next-state
  logic [NUM_IRQ-1:0] mask_n, raw_n, masked_n, raw_base;
  logic [NUM_NMI-1:0] nmi_n, nmi_base;
  logic               fatal_n, recalc;
  logic [VEC_W-1:0]   vec_n;

  always_comb begin
    mask_n   = wr[RG_MASK] ? bus_wdata[NUM_IRQ-1:0] : mask_q;
    raw_base = wr[RG_RAW]  ? bus_wdata[NUM_IRQ-1:0] : raw_q;
    raw_n    = (irq_chg & irq_lines) | (~irq_chg & raw_base);
    recalc   = (|irq_chg) || wr[RG_MASK] || wr[RG_RAW];
    if (recalc)              masked_n = raw_n & mask_n;
    else if (wr[RG_MASKED])  masked_n = bus_wdata[NUM_IRQ-1:0];
    else                     masked_n = masked_q;
    nmi_base = wr[RG_NMI] ? bus_wdata[NUM_NMI-1:0] : nmi_q;
    nmi_n    = (nmi_chg & nmi_lines) | (~nmi_chg & nmi_base);
    fatal_n  = fatal_in ? 1'b1 : (wr[RG_FATAL] ? bus_wdata[0] : fatal_q);
  end

  ivc_vec_encode #(.W(NUM_IRQ), .VEC_W(VEC_W), .SHARED_VEC(SHARED_VEC)) u_enc (
    .pend(masked_n), .vec(vec_n)
  );

  // read mux
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (word_acc && !bus_we && !bad_acc) begin
      unique case (1'b1)
        hit[RG_MASK]:   rd_mux = DATA_W'(mask_q);
        hit[RG_RAW]:    rd_mux = DATA_W'(raw_q);
        hit[RG_MASKED]: rd_mux = DATA_W'(masked_q);
        hit[RG_NMI]:    rd_mux = DATA_W'(nmi_q);
        hit[RG_FATAL]:  rd_mux = DATA_W'(fatal_q);
        default:        rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      raw_q     <= '0;
      masked_q  <= '0;
      nmi_q     <= '0;
      fatal_q   <= 1'b0;
      irq_req   <= 1'b0;
      irq_vec   <= '0;
      nmi_req   <= 1'b0;
      fatal_o   <= 1'b0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      mask_q    <= mask_n;
      raw_q     <= raw_n;
      masked_q  <= masked_n;
      nmi_q     <= nmi_n;
      fatal_q   <= fatal_n;
      irq_req   <= |masked_n;
      irq_vec   <= vec_n;
      nmi_req   <= |nmi_n;
      fatal_o   <= fatal_o | fatal_in;
      bus_rdata <= rd_mux;
      bus_err   <= bad_acc;
    end
  end

  // checks next to the logic they guard
  assert_req_tracks_masked_R2: assert property (@(posedge clk) disable iff (rst)
    irq_req == (masked_q != '0));
  assert_vec_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (int'(irq_vec) >= SHARED_VEC && int'(irq_vec) <= MAX_VEC));
  assert_idle_vec_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vec == '0));
  assert_nmi_req_R6: assert property (@(posedge clk) disable iff (rst)
    nmi_req == (nmi_q != '0));
  assert_narrow_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_size != SZ_WORD) |=> $stable(mask_q));
  assert_err_needs_access_R9: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel));
  assert_fatal_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    fatal_o |=> fatal_o);
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  localparam int NI = 30;
  localparam int NN = 2;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [NI-1:0] irq_lines;
  logic [NN-1:0] nmi_lines;
  logic          fatal_in;
  logic          bus_sel, bus_we;
  logic [1:0]    bus_size;
  logic [4:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          bus_err, irq_req, nmi_req, fatal_o;
  logic [7:0]    irq_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .nmi_lines(nmi_lines),
    .fatal_in(fatal_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_req(irq_req),
    .irq_vec(irq_vec), .nmi_req(nmi_req), .fatal_o(fatal_o)
  );

  localparam logic [NI-1:0] T_MASK [NV] = '{
    30'h3FFFFFFF, 30'h3FFFFFFF, 30'h3FFFFFFF, 30'h3FFFFFFF,
    30'h00000001, 30'h00000000, 30'h00000080, 30'h3FFFFFFF };
  localparam logic [NI-1:0] T_LINE [NV] = '{
    30'h00000000, 30'h00000001, 30'h20000000, 30'h00000088,
    30'h00000009, 30'h3FFFFFFF, 30'h00000088, 30'h3FFFFFFF };
  localparam logic [7:0] T_VEC [NV] = '{
    8'h00, 8'h31, 8'h4E, 8'h30, 8'h31, 8'h00, 8'h38, 8'h30 };
  localparam string T_REQ [NV] = '{
    "R5", "R3", "R3", "R4", "R3", "R5", "R3", "R4" };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called just after a falling edge; returns after the next falling edge
  task automatic access(input logic we, input logic [1:0] sz,
                        input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_lines = '0; nmi_lines = '0; fatal_in = 1'b0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_size = 2'd2; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11", "irq_req", 32'(irq_req), 0);
    chk("R11", "irq_vec", 32'(irq_vec), 0);
    chk("R11", "nmi_req", 32'(nmi_req), 0);
    chk("R11", "fatal_o", 32'(fatal_o), 0);
    access(1'b0, 2'd2, 5'h00, 0);
    chk("R11", "mask after reset", bus_rdata, 0);

    // table walk: R3 R4 R5
    for (int t = 0; t < NV; t++) begin
      access(1'b1, 2'd2, 5'h00, 32'(T_MASK[t]));
      irq_lines = T_LINE[t];
      @(negedge clk);
      chk(T_REQ[t], $sformatf("vec entry %0d", t), 32'(irq_vec), 32'(T_VEC[t]));
      chk(T_REQ[t], $sformatf("req entry %0d", t), 32'(irq_req),
          (T_VEC[t] != 0) ? 1 : 0);
    end

    // R1 R2: raw and masked status
    access(1'b1, 2'd2, 5'h00, 32'h0F0);
    irq_lines = 30'h0FF;
    @(negedge clk);
    access(1'b0, 2'd2, 5'h04, 0);
    chk("R1", "raw status", bus_rdata, 32'h0FF);
    access(1'b0, 2'd2, 5'h08, 0);
    chk("R2", "masked status", bus_rdata, 32'h0F0);
    chk("R4", "vec shared", 32'(irq_vec), 32'h30);

    // R7: narrow accesses
    access(1'b1, 2'd0, 5'h00, 32'hFFFF_FFFF);
    access(1'b1, 2'd1, 5'h00, 32'hFFFF_FFFF);
    access(1'b0, 2'd2, 5'h00, 0);
    chk("R7", "mask after narrow writes", bus_rdata, 32'h0F0);
    access(1'b0, 2'd0, 5'h04, 0);
    chk("R7", "byte read", bus_rdata, 0);
    access(1'b0, 2'd1, 5'h04, 0);
    chk("R7", "halfword read", bus_rdata, 0);

    // R8: direct loads
    irq_lines = '0;
    @(negedge clk);
    access(1'b1, 2'd2, 5'h00, 32'h3FFF_FFFF);
    access(1'b1, 2'd2, 5'h04, 32'h4);
    chk("R8", "vec after raw write", 32'(irq_vec), 32'h33);
    access(1'b1, 2'd2, 5'h08, 32'h3);
    chk("R8", "vec after masked write", 32'(irq_vec), 32'h30);
    access(1'b0, 2'd2, 5'h08, 0);
    chk("R8", "masked readback", bus_rdata, 32'h3);

    // R9: undefined offsets
    access(1'b0, 2'd2, 5'h14, 0);
    chk("R9", "undef read data", bus_rdata, 0);
    chk("R9", "undef read err", 32'(bus_err), 1);
    access(1'b1, 2'd2, 5'h18, 32'h0);
    chk("R9", "undef write err", 32'(bus_err), 1);
    access(1'b0, 2'd2, 5'h00, 0);
    chk("R9", "err clears", 32'(bus_err), 0);
    chk("R9", "mask untouched", bus_rdata, 32'h3FFF_FFFF);

    // R6: non-maskable path
    nmi_lines = 2'b10;
    @(negedge clk);
    chk("R6", "nmi_req set", 32'(nmi_req), 1);
    access(1'b0, 2'd2, 5'h0C, 0);
    chk("R6", "nmi status", bus_rdata, 32'h2);
    nmi_lines = 2'b00;
    @(negedge clk);
    chk("R6", "nmi_req clear", 32'(nmi_req), 0);

    // R10: fatal sticky
    fatal_in = 1'b1;
    @(negedge clk);
    fatal_in = 1'b0;
    chk("R10", "fatal_o set", 32'(fatal_o), 1);
    access(1'b1, 2'd2, 5'h10, 32'h0);
    repeat (3) @(negedge clk);
    chk("R10", "fatal_o sticky", 32'(fatal_o), 1);
    access(1'b1, 2'd2, 5'h10, 32'h0);
    access(1'b0, 2'd2, 5'h10, 0);
    chk("R10", "fatal status written", bus_rdata, 0);

    // R11: reset clears
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "fatal_o after reset", 32'(fatal_o), 0);
    chk("R11", "irq_req after reset", 32'(irq_req), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule